// File: doc/BRIEF.md
# Command-Stepped Lane Processing Unit

This block is a small SIMD processing unit placed beside one DRAM bank. It has no free-running program of its own. Every read or write command that reaches the bank executes exactly one instruction from a 32-entry command store, and the program counter then moves on. The host loads the store once through a plain word-write port. After that, ordinary bank traffic drives the computation. Bank read data becomes an operand, and on write commands the unit can supply the burst that goes into the bank.

Each lane is 16 bits wide and a vector register holds 16 lanes, so one register covers one 256-bit burst. There are two vector register files (A and B) and two scalar files (A and M), each with 8 entries. Scalars are broadcast across all lanes when read. An instruction flag lets the A and B vector indices come from the access address instead of the instruction. This allows a run of commands over consecutive addresses to walk through the registers. Loops are built from a single countdown counter. It is checked right after the instruction that precedes a loop instruction, so a loop costs no extra command.

Top module: `pimu_unit`

## Requirements
- R1: After reset `wr_valid` is 0 and `wr_data` is 0. The program counter, loop counter, all registers and all command-store words are zero.
- R2: With `cmd_valid` low, the program counter and loop counter hold. Each accepted command executes the instruction at the program counter and then advances it.
- R3: Command-store words are written through `ld_en`/`ld_addr`/`ld_word` and are laid out as follows.
  - Opcode is in [31:28], with codes EXIT=0, MOV=1, FILL=2, ADD=3, MUL=4, MAC=5, MAD=6, JUMP=7; other codes do nothing but advance.
  - The address-index flag is in [27].
  - The destination file and index are in [26:24]/[23:21].
  - Operand a is in [20:18]/[17:15], operand b in [14:12]/[11:9], and operand c in [8:6]/[5:3].
  - File codes are vector A=0, vector B=1, scalar A=2, scalar M=3, bank burst=4.
  - For a JUMP, the count is in [15:8] and the backward offset in [4:0].
- R4: On a read command, MOV and FILL copy operand a into the destination. A scalar destination takes lane 0, and a scalar source is broadcast to all 16 lanes.
- R5: On a read command, ADD gives a+b and MUL gives a*b in each lane, modulo 2^16. Lanes are never summed together.
- R6: On a read command, MAC gives a*b plus the old destination value, so it accumulates. MAD gives a*b+c.
- R7: On a write command, FILL drives operand a on `wr_data` with `wr_valid` high one cycle later; the bank operand reads as zero on writes. Any other instruction on a write changes no register and gives `wr_valid`=0 with `wr_data`=0.
- R8: With the address-index flag set, every vector A index comes from `cmd_col[2:0]` and every vector B index from `cmd_row[2:0]`.
- R9: After a non-EXIT command, if the next word is a JUMP, the loop counter updates and the program counter branches or falls through.
  - The loop counter is loaded with the count when it is zero, and is otherwise decremented.
  - A nonzero result branches to (JUMP address − offset) mod 32; a zero result skips past the JUMP.
  - A loop body therefore runs count+1 times.
- R10: A command that meets EXIT returns registers, program counter and loop counter to zero. A command arriving while the program counter is 32 has no effect.
- R11: A JUMP reached by a command itself behaves as a no-op that advances the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Command-store write strobe |
| ld_addr | input | 5 | Command-store write address |
| ld_word | input | 32 | Instruction word to store |
| cmd_valid | input | 1 | Bank command strobe |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_row | input | 14 | Row address of the access |
| cmd_col | input | 6 | Column address of the access |
| rd_data | input | 256 | Burst fetched from the bank on reads |
| wr_valid | output | 1 | `wr_data` carries a burst for the bank |
| wr_data | output | 256 | Burst to be written into the bank |

## Verification
Random programs exercise every opcode and file code. They run under a random mix of read and write commands with random bank data and addresses. This separates lane arithmetic, scalar broadcast, write-side suppression and address-derived indexing against a bench model. Directed programs cover the cases random stimulus rarely reaches:
- a counted loop, whose result must be exactly count+1 accumulations;
- EXIT, which clears state that was previously written;
- a full store run to the end, after which commands have no effect;
- a JUMP hit directly by a command.

// File: rtl/pimu_pkg.sv
package pimu_pkg;
  localparam int INSN_W = 32;
  localparam int JC_W   = 8;
  localparam int OFF_W  = 5;

  localparam logic [3:0] OP_EXIT = 4'd0;
  localparam logic [3:0] OP_MOV  = 4'd1;
  localparam logic [3:0] OP_FILL = 4'd2;
  localparam logic [3:0] OP_ADD  = 4'd3;
  localparam logic [3:0] OP_MUL  = 4'd4;
  localparam logic [3:0] OP_MAC  = 4'd5;
  localparam logic [3:0] OP_MAD  = 4'd6;
  localparam logic [3:0] OP_JUMP = 4'd7;

  localparam logic [2:0] F_VA = 3'd0;
  localparam logic [2:0] F_VB = 3'd1;
  localparam logic [2:0] F_SA = 3'd2;
  localparam logic [2:0] F_SM = 3'd3;
  localparam logic [2:0] F_BK = 3'd4;

  typedef struct packed {
    logic [3:0] op;
    logic       aam;
    logic [2:0] d_f;
    logic [2:0] d_i;
    logic [2:0] a_f;
    logic [2:0] a_i;
    logic [2:0] b_f;
    logic [2:0] b_i;
    logic [2:0] c_f;
    logic [2:0] c_i;
    logic [2:0] pad;
  } insn_t;
endpackage

// File: rtl/pimu_crf.sv
module pimu_crf #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [WORD_W-1:0] ld_word,
  input  logic [AW-1:0]     ra_addr,
  output logic [WORD_W-1:0] ra_word,
  input  logic [AW-1:0]     rb_addr,
  output logic [WORD_W-1:0] rb_word
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (ld_en) begin
      mem_q[ld_addr] <= ld_word;
    end
  end

  assign ra_word = mem_q[ra_addr];
  assign rb_word = mem_q[rb_addr];
endmodule

// File: rtl/pimu_lane_alu.sv
module pimu_lane_alu
  import pimu_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int LANE_W = 16,
  localparam int BW    = LANES * LANE_W
) (
  input  logic [3:0]    op,
  input  logic [BW-1:0] src_a,
  input  logic [BW-1:0] src_b,
  input  logic [BW-1:0] src_c,
  input  logic [BW-1:0] acc,
  output logic [BW-1:0] res
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] a, b, c, d, p, r;
    assign a = src_a[g*LANE_W +: LANE_W];
    assign b = src_b[g*LANE_W +: LANE_W];
    assign c = src_c[g*LANE_W +: LANE_W];
    assign d = acc[g*LANE_W +: LANE_W];
    assign p = a * b;
    always_comb begin
      case (op)
        OP_ADD:  r = a + b;
        OP_MUL:  r = p;
        OP_MAC:  r = p + d;
        OP_MAD:  r = p + c;
        default: r = a;
      endcase
    end
    assign res[g*LANE_W +: LANE_W] = r;
  end
endmodule

// File: rtl/pimu_seq.sv
module pimu_seq
  import pimu_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int PC_W = AW + 1
) (
  input  logic [PC_W-1:0]   pc_q,
  input  logic [JC_W-1:0]   jc_q,
  input  logic              step,
  input  logic [INSN_W-1:0] nx_word,
  output logic [PC_W-1:0]   pc_d,
  output logic [JC_W-1:0]   jc_d
);
  logic [PC_W-1:0]  pc_inc;
  logic             nx_jump;
  logic [JC_W-1:0]  jc_tmp;
  logic [OFF_W-1:0] off;
  logic [AW-1:0]    target;
  logic             unused_nx;

  assign pc_inc    = pc_q + PC_W'(1);
  assign nx_jump   = (pc_inc < PC_W'(DEPTH)) && (nx_word[31:28] == OP_JUMP);
  assign jc_tmp    = (jc_q == '0) ? nx_word[15:8] : jc_q - JC_W'(1);
  assign off       = nx_word[4:0];
  assign target    = pc_inc[AW-1:0] - AW'(off);
  assign unused_nx = ^{nx_word[27:16], nx_word[7:5]};

  always_comb begin
    pc_d = pc_q;
    jc_d = jc_q;
    if (step) begin
      if (nx_jump) begin
        jc_d = jc_tmp;
        pc_d = (jc_tmp != '0) ? {1'b0, target} : pc_inc + PC_W'(1);
      end else begin
        pc_d = pc_inc;
      end
    end
  end
endmodule

// File: rtl/pimu_unit.sv
module pimu_unit
  import pimu_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int LANE_W = 16,
  parameter int VREGS  = 8,
  parameter int SREGS  = 8,
  parameter int DEPTH  = 32,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 6,
  localparam int BURST_W = LANES * LANE_W,
  localparam int AW      = $clog2(DEPTH),
  localparam int PC_W    = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [AW-1:0]      ld_addr,
  input  logic [INSN_W-1:0]  ld_word,
  input  logic               cmd_valid,
  input  logic               cmd_write,
  input  logic [ROW_W-1:0]   cmd_row,
  input  logic [COL_W-1:0]   cmd_col,
  input  logic [BURST_W-1:0] rd_data,
  output logic               wr_valid,
  output logic [BURST_W-1:0] wr_data
);
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [PC_W-1:0]    pc_q, pc_d, pc_step;
  logic [JC_W-1:0]    jc_q, jc_d, jc_step;
  logic [BURST_W-1:0] va_q [VREGS];
  logic [BURST_W-1:0] va_d [VREGS];
  logic [BURST_W-1:0] vb_q [VREGS];
  logic [BURST_W-1:0] vb_d [VREGS];
  logic [LANE_W-1:0]  sa_q [SREGS];
  logic [LANE_W-1:0]  sa_d [SREGS];
  logic [LANE_W-1:0]  sm_q [SREGS];
  logic [LANE_W-1:0]  sm_d [SREGS];
  logic               wval_q, wval_d;
  logic [BURST_W-1:0] wdat_q, wdat_d;

  logic [INSN_W-1:0]  cur_w, nx_w;
  insn_t              cur;
  logic               run, is_exit, writes_reg;
  logic [2:0]         ia_sel, ib_sel;
  logic [BURST_W-1:0] opa, opb, opc, opd, alu_res;
  logic               unused_bits;

  pimu_crf #(.DEPTH(DEPTH), .WORD_W(INSN_W)) u_crf (
    .clk(clk), .rst_n(rst_sync_n),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_word(ld_word),
    .ra_addr(pc_q[AW-1:0]), .ra_word(cur_w),
    .rb_addr(pc_q[AW-1:0] + AW'(1)), .rb_word(nx_w)
  );

  assign cur         = insn_t'(cur_w);
  assign run         = cmd_valid && (pc_q < PC_W'(DEPTH));
  assign is_exit     = (cur.op == OP_EXIT);
  assign writes_reg  = (cur.op >= OP_MOV) && (cur.op <= OP_MAD);
  assign ia_sel      = cmd_col[2:0];
  assign ib_sel      = cmd_row[2:0];
  assign unused_bits = ^{cur.pad, cmd_row[ROW_W-1:3], cmd_col[COL_W-1:3]};

  function automatic logic [BURST_W-1:0] pick(input logic [2:0] f, input logic [2:0] i);
    logic [2:0] ia, ib;
    ia = cur.aam ? ia_sel : i;
    ib = cur.aam ? ib_sel : i;
    case (f)
      F_VA:    pick = va_q[ia];
      F_VB:    pick = vb_q[ib];
      F_SA:    pick = {LANES{sa_q[i]}};
      F_SM:    pick = {LANES{sm_q[i]}};
      F_BK:    pick = cmd_write ? '0 : rd_data;
      default: pick = '0;
    endcase
  endfunction

  always_comb begin
    opa = pick(cur.a_f, cur.a_i);
    opb = pick(cur.b_f, cur.b_i);
    opc = pick(cur.c_f, cur.c_i);
    opd = pick(cur.d_f, cur.d_i);
  end

  pimu_lane_alu #(.LANES(LANES), .LANE_W(LANE_W)) u_alu (
    .op(cur.op), .src_a(opa), .src_b(opb), .src_c(opc), .acc(opd), .res(alu_res)
  );

  pimu_seq #(.DEPTH(DEPTH)) u_seq (
    .pc_q(pc_q), .jc_q(jc_q), .step(run && !is_exit),
    .nx_word(nx_w), .pc_d(pc_step), .jc_d(jc_step)
  );

  // next state
  always_comb begin
    va_d   = va_q;
    vb_d   = vb_q;
    sa_d   = sa_q;
    sm_d   = sm_q;
    pc_d   = pc_step;
    jc_d   = jc_step;
    wval_d = 1'b0;
    wdat_d = '0;
    if (run) begin
      if (is_exit) begin
        for (int i = 0; i < VREGS; i++) begin
          va_d[i] = '0;
          vb_d[i] = '0;
        end
        for (int i = 0; i < SREGS; i++) begin
          sa_d[i] = '0;
          sm_d[i] = '0;
        end
        pc_d = '0;
        jc_d = '0;
      end else if (!cmd_write) begin
        if (writes_reg) begin
          case (cur.d_f)
            F_VA:    va_d[cur.aam ? ia_sel : cur.d_i] = alu_res;
            F_VB:    vb_d[cur.aam ? ib_sel : cur.d_i] = alu_res;
            F_SA:    sa_d[cur.d_i] = alu_res[LANE_W-1:0];
            F_SM:    sm_d[cur.d_i] = alu_res[LANE_W-1:0];
            default: ;
          endcase
        end
      end else if (cur.op == OP_FILL) begin
        wval_d = 1'b1;
        wdat_d = opa;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q   <= '0;
      jc_q   <= '0;
      wval_q <= 1'b0;
      wdat_q <= '0;
      for (int i = 0; i < VREGS; i++) begin
        va_q[i] <= '0;
        vb_q[i] <= '0;
      end
      for (int i = 0; i < SREGS; i++) begin
        sa_q[i] <= '0;
        sm_q[i] <= '0;
      end
    end else begin
      wval_q <= wval_d;
      wdat_q <= wdat_d;
      if (run) begin
        pc_q <= pc_d;
        jc_q <= jc_d;
        va_q <= va_d;
        vb_q <= vb_d;
        sa_q <= sa_d;
        sm_q <= sm_d;
      end
    end
  end

  assign wr_valid = wval_q;
  assign wr_data  = wdat_q;
endmodule

// File: rtl/pimu_unit_chk.sv
module pimu_unit_chk #(
  parameter int DEPTH   = 32,
  parameter int PC_W    = 6,
  parameter int JC_W    = 8,
  parameter int BURST_W = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_write,
  input logic               wr_valid,
  input logic [BURST_W-1:0] wr_data,
  input logic [PC_W-1:0]    pc_q,
  input logic [JC_W-1:0]    jc_q
);
  a_r7_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(cmd_valid && cmd_write));

  a_r7_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (wr_data == '0));

  a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(pc_q));

  a_r2_jc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(jc_q));

  a_r10_pc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= PC_W'(DEPTH));

  a_r10_dead_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && pc_q == PC_W'(DEPTH)) |=> (pc_q == PC_W'(DEPTH)) && !wr_valid);
endmodule

bind pimu_unit pimu_unit_chk #(
  .DEPTH(DEPTH), .PC_W(PC_W), .JC_W(pimu_pkg::JC_W), .BURST_W(BURST_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .wr_valid(wr_valid), .wr_data(wr_data), .pc_q(pc_q), .jc_q(jc_q)
);

// File: tb/test_pimu_unit.sv
`timescale 1ns/1ps
module test_pimu_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         ld_en;
  logic [4:0]   ld_addr;
  logic [31:0]  ld_word;
  logic         cmd_valid, cmd_write;
  logic [13:0]  cmd_row;
  logic [5:0]   cmd_col;
  logic [255:0] rd_data;
  logic         wr_valid;
  logic [255:0] wr_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pimu_unit i_pimu_unit (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_word(ld_word),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .rd_data(rd_data), .wr_valid(wr_valid), .wr_data(wr_data)
  );

  // bench model of the requirements
  logic [255:0] m_va [8];
  logic [255:0] m_vb [8];
  logic [15:0]  m_sa [8];
  logic [15:0]  m_sm [8];
  logic [31:0]  m_crf [32];
  int           m_pc, m_jc;

  function automatic logic [31:0] mk(int op, bit aam, int df, int di, int af, int ai,
                                     int bf, int bi, int cf, int ci);
    return {op[3:0], aam, df[2:0], di[2:0], af[2:0], ai[2:0], bf[2:0], bi[2:0],
            cf[2:0], ci[2:0], 3'b000};
  endfunction

  function automatic logic [31:0] mkj(int cnt, int off);
    return {4'd7, 12'd0, cnt[7:0], 3'd0, off[4:0]};
  endfunction

  function automatic logic [255:0] rnd_burst();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic m_clear_regs();
    for (int k = 0; k < 8; k++) begin
      m_va[k] = '0; m_vb[k] = '0; m_sa[k] = '0; m_sm[k] = '0;
    end
    m_pc = 0; m_jc = 0;
  endtask

  function automatic logic [255:0] m_get(logic [2:0] f, logic [2:0] i, bit aam, bit w,
                                         logic [13:0] row, logic [5:0] col, logic [255:0] rd);
    case (f)
      3'd0: return m_va[aam ? col[2:0] : i];
      3'd1: return m_vb[aam ? row[2:0] : i];
      3'd2: return {16{m_sa[i]}};
      3'd3: return {16{m_sm[i]}};
      3'd4: return w ? 256'd0 : rd;
      default: return 256'd0;
    endcase
  endfunction

  task automatic m_step(bit w, logic [13:0] row, logic [5:0] col, logic [255:0] rd,
                        output bit ev, output logic [255:0] ed);
    logic [31:0] ins;
    logic [255:0] a, b, c, d, res;
    logic [15:0] la, lb, lc, ld, r;
    int op, nx, t;
    bit aam;
    ev = 0; ed = '0;
    if (m_pc < 32) begin
      ins = m_crf[m_pc];
      op  = int'(ins[31:28]);
      aam = ins[27];
      if (op == 0) begin
        m_clear_regs();
      end else begin
        a = m_get(ins[20:18], ins[17:15], aam, w, row, col, rd);
        b = m_get(ins[14:12], ins[11:9],  aam, w, row, col, rd);
        c = m_get(ins[8:6],   ins[5:3],   aam, w, row, col, rd);
        d = m_get(ins[26:24], ins[23:21], aam, w, row, col, rd);
        if (!w) begin
          if (op >= 1 && op <= 6) begin
            for (int l = 0; l < 16; l++) begin
              la = a[l*16 +: 16]; lb = b[l*16 +: 16];
              lc = c[l*16 +: 16]; ld = d[l*16 +: 16];
              case (op)
                3: r = la + lb;
                4: r = la * lb;
                5: r = la * lb + ld;
                6: r = la * lb + lc;
                default: r = la;
              endcase
              res[l*16 +: 16] = r;
            end
            case (ins[26:24])
              3'd0: m_va[aam ? col[2:0] : ins[23:21]] = res;
              3'd1: m_vb[aam ? row[2:0] : ins[23:21]] = res;
              3'd2: m_sa[ins[23:21]] = res[15:0];
              3'd3: m_sm[ins[23:21]] = res[15:0];
              default: ;
            endcase
          end
        end else if (op == 2) begin
          ev = 1; ed = a;
        end
        nx = m_pc + 1;
        if (nx < 32 && m_crf[nx][31:28] == 4'd7) begin
          if (m_jc == 0) t = int'(m_crf[nx][15:8]);
          else           t = m_jc - 1;
          m_jc = t;
          if (t != 0) m_pc = (nx - int'(m_crf[nx][4:0])) & 31;
          else        m_pc = nx + 1;
        end else begin
          m_pc = nx;
        end
      end
    end
  endtask

  task automatic check(string tag, bit ok, bit av, logic [255:0] ad, bit xv, logic [255:0] xd);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b data=%h expected valid=%0b data=%h", tag, av, ad, xv, xd);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ld_en = 0; ld_addr = '0; ld_word = '0;
    cmd_valid = 0; cmd_write = 0; cmd_row = '0; cmd_col = '0; rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_clear_regs();
    for (int k = 0; k < 32; k++) m_crf[k] = '0;
  endtask

  task automatic load(int addr, logic [31:0] w);
    ld_en = 1; ld_addr = addr[4:0]; ld_word = w;
    m_crf[addr] = w;
    @(posedge clk); @(negedge clk);
    ld_en = 0;
  endtask

  task automatic do_cmd(string tag, bit w, logic [13:0] row, logic [5:0] col, logic [255:0] rd);
    bit ev;
    logic [255:0] ed;
    m_step(w, row, col, rd, ev, ed);
    cmd_valid = 1; cmd_write = w; cmd_row = row; cmd_col = col; rd_data = rd;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
    check(tag, (wr_valid === ev) && (wr_data === ed), wr_valid, wr_data, ev, ed);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [255:0] ones, dat;
    void'($urandom(32'd20240611));
    ones = {16{16'h0001}};

    // R1 reset state
    do_reset();
    check("R1 reset outputs", (wr_valid === 1'b0) && (wr_data === '0), wr_valid, wr_data, 1'b0, '0);
    load(0, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    do_cmd("R1 registers zero after reset", 1, 14'd0, 6'd0, '0);

    // R4 R5 R6 arithmetic with scalar broadcast
    do_reset();
    load(0, mk(1, 0, 0, 2, 4, 0, 0, 0, 0, 0));   // MOV va2 <- bank
    load(1, mk(1, 0, 2, 3, 4, 0, 0, 0, 0, 0));   // MOV sa3 <- bank lane0
    load(2, mk(3, 0, 1, 1, 0, 2, 2, 3, 0, 0));   // ADD vb1 = va2 + sa3
    load(3, mk(4, 0, 0, 4, 0, 2, 0, 2, 0, 0));   // MUL va4 = va2*va2
    load(4, mk(5, 0, 1, 1, 0, 2, 2, 3, 0, 0));   // MAC vb1 += va2*sa3
    load(5, mk(6, 0, 0, 5, 0, 2, 2, 3, 1, 1));   // MAD va5 = va2*sa3+vb1
    load(6, mk(2, 0, 0, 0, 0, 4, 0, 0, 0, 0));   // FILL va4
    load(7, mk(2, 0, 0, 0, 1, 1, 0, 0, 0, 0));   // FILL vb1
    load(8, mk(2, 0, 0, 0, 0, 5, 0, 0, 0, 0));   // FILL va5
    load(9, mk(2, 0, 0, 0, 3, 0, 0, 0, 0, 0));   // FILL sm0 (zero)
    dat = rnd_burst();
    do_cmd("R4 mov bank", 0, 14'd0, 6'd0, dat);
    do_cmd("R4 mov scalar", 0, 14'd0, 6'd0, rnd_burst());
    do_cmd("R5 add", 0, 14'd0, 6'd0, rnd_burst());
    do_cmd("R5 mul", 0, 14'd0, 6'd0, rnd_burst());
    do_cmd("R6 mac", 0, 14'd0, 6'd0, rnd_burst());
    do_cmd("R6 mad", 0, 14'd0, 6'd0, rnd_burst());
    do_cmd("R5 fill mul result", 1, 14'd0, 6'd0, rnd_burst());
    do_cmd("R6 fill mac result", 1, 14'd0, 6'd0, rnd_burst());
    do_cmd("R6 fill mad result", 1, 14'd0, 6'd0, rnd_burst());
    do_cmd("R4 scalar broadcast zero", 1, 14'd0, 6'd0, rnd_burst());

    // R7 non-FILL on write is ignored
    do_reset();
    load(0, mk(1, 0, 0, 0, 4, 0, 0, 0, 0, 0));
    load(1, mk(1, 0, 0, 0, 4, 0, 0, 0, 0, 0));
    load(2, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    dat = rnd_burst();
    do_cmd("R7 mov read", 0, 14'd0, 6'd0, dat);
    do_cmd("R7 mov on write no burst", 1, 14'd0, 6'd0, rnd_burst());
    do_cmd("R7 register untouched by write", 1, 14'd0, 6'd0, rnd_burst());
    check("R7 explicit value", wr_data === dat, wr_valid, wr_data, 1'b1, dat);

    // R8 address-derived indices
    do_reset();
    load(0, mk(1, 1, 0, 0, 4, 0, 0, 0, 0, 0));   // MOV aam va[col] <- bank
    load(1, mk(1, 1, 1, 0, 4, 0, 0, 0, 0, 0));   // MOV aam vb[row] <- bank
    load(2, mk(2, 0, 0, 0, 0, 5, 0, 0, 0, 0));   // FILL va5
    load(3, mk(2, 0, 0, 0, 1, 3, 0, 0, 0, 0));   // FILL vb3
    load(4, mk(2, 1, 0, 0, 0, 0, 0, 0, 0, 0));   // FILL aam va[col]
    do_cmd("R8 aam write va", 0, 14'h2a01, 6'd13, rnd_burst());
    do_cmd("R8 aam write vb", 0, 14'h1233, 6'd2, rnd_burst());
    do_cmd("R8 read va5", 1, 14'd0, 6'd0, '0);
    do_cmd("R8 read vb3", 1, 14'd0, 6'd0, '0);
    do_cmd("R8 aam source", 1, 14'd0, 6'd5, '0);

    // R9 counted loop: body runs count+1 times
    do_reset();
    load(0, mk(1, 0, 0, 1, 4, 0, 0, 0, 0, 0));
    load(1, mk(3, 0, 0, 0, 0, 0, 0, 1, 0, 0));
    load(2, mkj(3, 1));
    load(3, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    do_cmd("R9 setup", 0, 14'd0, 6'd0, ones);
    for (int k = 0; k < 4; k++) do_cmd("R9 loop body", 0, 14'd0, 6'd0, rnd_burst());
    do_cmd("R9 loop result", 1, 14'd0, 6'd0, '0);
    check("R9 four passes", wr_data === {16{16'd4}}, wr_valid, wr_data, 1'b1, {16{16'd4}});

    // R10 EXIT clears state; end of store is dead
    do_reset();
    load(0, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    load(1, mk(1, 0, 0, 0, 4, 0, 0, 0, 0, 0));
    load(2, 32'd0);
    do_cmd("R10 first fill", 1, 14'd0, 6'd0, '0);
    do_cmd("R10 mov", 0, 14'd0, 6'd0, rnd_burst());
    do_cmd("R10 exit", 0, 14'd0, 6'd0, rnd_burst());
    do_cmd("R10 cleared after exit", 1, 14'd0, 6'd0, '0);
    check("R10 explicit zero", (wr_valid === 1'b1) && (wr_data === '0), wr_valid, wr_data, 1'b1, '0);
    do_reset();
    for (int k = 0; k < 31; k++) load(k, mk(1, 0, 0, 0, 4, 0, 0, 0, 0, 0));
    load(31, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    for (int k = 0; k < 31; k++) do_cmd("R10 walk", 0, 14'd0, 6'd0, rnd_burst());
    do_cmd("R10 last slot", 1, 14'd0, 6'd0, '0);
    do_cmd("R10 past end write", 1, 14'd0, 6'd0, '0);
    check("R10 no burst past end", wr_valid === 1'b0, wr_valid, wr_data, 1'b0, '0);

    // R11 JUMP hit by a command
    do_reset();
    load(0, mkj(2, 1));
    load(1, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    do_cmd("R11 jump as no-op", 0, 14'd0, 6'd0, rnd_burst());
    do_cmd("R11 advanced to fill", 1, 14'd0, 6'd0, '0);

    // R2 R3 random programs and command mixes
    for (int round = 0; round < 30; round++) begin
      do_reset();
      for (int k = 0; k < 32; k++) begin
        int sel;
        logic [31:0] w;
        sel = int'($urandom % 16);
        if (sel == 0)       w = 32'd0;
        else if (sel == 11) w = mkj(int'($urandom % 4), int'($urandom % 4) + 1);
        else if (sel == 12) w = {4'hc, 28'($urandom)};
        else begin
          int op;
          case (sel)
            1, 2:    op = 1;
            3, 4, 5: op = 2;
            6:       op = 3;
            7:       op = 4;
            8, 9:    op = 5;
            default: op = 6;
          endcase
          w = mk(op, ($urandom % 4) == 0, int'($urandom % 5), int'($urandom % 8),
                 int'($urandom % 5), int'($urandom % 8), int'($urandom % 5), int'($urandom % 8),
                 int'($urandom % 5), int'($urandom % 8));
        end
        load(k, w);
      end
      for (int k = 0; k < 48; k++) begin
        do_cmd("R2 R3 random program", ($urandom % 3) == 0, 14'($urandom), 6'($urandom),
               rnd_burst());
        if (($urandom % 8) == 0) @(negedge clk);
      end
    end

    finish_run();
  end
endmodule